// File: doc/BRIEF.md
# Two-Wire EEPROM Configuration Loader

This block fetches a fixed image of configuration words from a two-wire serial EEPROM once reset has been released, and hands each word to the chip's register file. It runs entirely on the PCI clock. The serial clock comes from dividing that clock. SDA is driven open-drain: the block can only pull the line low or let it float.

Once `en` is seen high, the loader sends a start condition and the device address with the write direction, then the starting word offset. A repeated start follows, then the device address with the read direction. After that it clocks in a run of bytes in sequence. It acknowledges every byte except the final one, which it answers with a not-acknowledge, and it then sends a stop. Four bytes make one 32-bit word, the first byte received being the least significant. Every finished word appears on a write port with a one-cycle strobe and an incrementing word index. If any byte the loader sends is not acknowledged, it stops the bus, raises the error flag and performs no writes. The register defaults stay in place in that case.

The phase length, device address, starting offset, word count and bytes per word are parameters. The defaults are 256 clocks per phase, 16 words, 4 bytes per word and address 0x50.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While `rst_n` is low (synchronous, active-low) and after reset until `en` is seen high, `scl_out` is 1, `sda_oe` is 0, `wr_en`, `done` and `err` are 0, and the bus stays idle.
- R2: During every data or acknowledge bit, SCL is low for exactly HALF_CLKS clocks and then high for exactly HALF_CLKS clocks, with no gap between consecutive bits.
- R3: A start or repeated start is a low phase of HALF_CLKS clocks with SDA released, followed by 2*HALF_CLKS clocks of SCL high, with SDA pulled low HALF_CLKS clocks into that high time. A stop is a low phase in which SDA is pulled, then 2*HALF_CLKS clocks of SCL high, with SDA released at its midpoint; SCL then stays high.
- R4: Within a bit, `sda_oe` changes only HALF_CLKS/2 clocks into the SCL low phase, and SDA is sampled HALF_CLKS/2 clocks into the SCL high phase. Bits go out and come in most significant bit first. `sda_oe`=1 means the line is pulled low.
- R5: The bus sequence is: start, byte {DEV_ADDR,0}, byte MEM_OFFSET, repeated start, byte {DEV_ADDR,1}, then WORDS*WORD_BYTES read bytes. During each acknowledge slot that follows a byte the loader sends, it releases SDA.
- R6: The loader pulls SDA low in the acknowledge slot of every read byte except the last, releases it for the last, and then issues a stop.
- R7: Each word carries the first of its bytes in bits 7:0, the second in 15:8, and so on.
- R8: Exactly WORDS writes occur, with `wr_addr` counting 0,1,2,... Each `wr_en` pulse lasts one cycle and starts two cycles after the sampling edge of the eighth bit of the word's last byte.
- R9: If SDA reads high in the acknowledge slot of any of the three sent bytes, `err` rises one cycle after that sample. A stop follows directly after that slot, and no write is made. `err` holds until reset.
- R10: `done` rises one cycle after the stop completes and holds until reset. The sequence runs only once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, the only clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Starts the load when seen high after reset |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_out | output | 1 | Serial clock, push-pull |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | AW | Word index of the write |
| wr_data | output | 8*WORD_BYTES | Assembled configuration word |
| done | output | 1 | Load finished (with or without error) |
| err | output | 1 | A sent byte was not acknowledged |

## Verification
The bench targets the seams of the protocol. The repeated start directly after an acknowledge slot shows whether SDA is released before SCL rises; getting it wrong turns the restart into a stop. The final read byte must get a not-acknowledge while every earlier one gets an acknowledge; mixing these up would leave the EEPROM driving the bus during the stop. A missing acknowledge is forced at each of the three sent bytes in turn; a design that only checked the first would go on reading and write garbage. Two data patterns, one placing a single set bit at either end of each byte, show up any reversed bit or byte order in the assembled words.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      OP_BIT   = 2'd0,
      OP_START = 2'd1,
      OP_STOP  = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      SQ_WAIT = 3'd0,
      SQ_STA  = 3'd1,
      SQ_TX   = 3'd2,
      SQ_RSTA = 3'd3,
      SQ_RX   = 3'd4,
      SQ_STO  = 3'd5,
      SQ_FIN  = 3'd6
   } seq_e;
endpackage

// File: rtl/ecl_bit_engine.sv
module ecl_bit_engine
   import ecl_pkg::*;
#(
   parameter int HALF_CLKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  op_e  op_kind,
   input  logic op_tx,
   input  logic sda_in,
   output logic op_ack,
   output logic busy,
   output logic scl,
   output logic sda_oe,
   output logic rx_bit,
   output logic rx_valid
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int QTR = HALF_CLKS / 2;
   localparam int CW  = $clog2(2 * HALF_CLKS);

   logic          busy_q, hi_q, tx_q, scl_q, oe_q, rx_q, rxv_q;
   op_e           kind_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] hi_last, hi_mid_m1;
   logic          at_end, low_oe;

   always_comb begin
      if (kind_q == OP_BIT) begin
         hi_last   = CW'(HALF_CLKS - 1);
         hi_mid_m1 = CW'(QTR - 1);
      end else begin
         hi_last   = CW'(2 * HALF_CLKS - 1);
         hi_mid_m1 = CW'(HALF_CLKS - 1);
      end
      case (kind_q)
         OP_START: low_oe = 1'b0;
         OP_STOP:  low_oe = 1'b1;
         default:  low_oe = ~tx_q;
      endcase
   end

   assign at_end = busy_q & hi_q & (cnt_q == hi_last);
   assign op_ack = op_valid & (~busy_q | at_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         hi_q   <= 1'b0;
         tx_q   <= 1'b1;
         kind_q <= OP_BIT;
         cnt_q  <= '0;
         scl_q  <= 1'b1;
         oe_q   <= 1'b0;
         rx_q   <= 1'b1;
         rxv_q  <= 1'b0;
      end else begin
         rxv_q <= 1'b0;
         if (op_ack) begin
            busy_q <= 1'b1;
            kind_q <= op_kind;
            tx_q   <= op_tx;
            hi_q   <= 1'b0;
            cnt_q  <= '0;
            scl_q  <= 1'b0;
         end else if (at_end) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (!hi_q) begin
               if (cnt_q == CW'(QTR - 1)) oe_q <= low_oe;
               if (cnt_q == CW'(HALF_CLKS - 1)) begin
                  hi_q  <= 1'b1;
                  cnt_q <= '0;
                  scl_q <= 1'b1;
               end
            end else if (cnt_q == hi_mid_m1) begin
               case (kind_q)
                  OP_START: oe_q <= 1'b1;
                  OP_STOP:  oe_q <= 1'b0;
                  default: begin
                     rx_q  <= sda_in;
                     rxv_q <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   assign busy     = busy_q;
   assign scl      = scl_q;
   assign sda_oe   = oe_q;
   assign rx_bit   = rx_q;
   assign rx_valid = rxv_q;
endmodule

// File: rtl/ecl_sequencer.sv
module ecl_sequencer
   import ecl_pkg::*;
#(
   parameter int         WORDS      = 16,
   parameter int         WORD_BYTES = 4,
   parameter logic [6:0] DEV_ADDR   = 7'h50,
   parameter logic [7:0] MEM_OFFSET = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       op_ack,
   input  logic       eng_busy,
   input  logic       rx_bit,
   input  logic       rx_valid,
   output logic       op_valid,
   output op_e        op_kind,
   output logic       op_tx,
   output logic       byte_valid,
   output logic [7:0] byte_data,
   output logic       done,
   output logic       err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NBYTES = WORDS * WORD_BYTES;
   localparam int BCW    = $clog2(NBYTES);

   seq_e           seg_q;
   logic [3:0]     bit_q;
   logic [1:0]     bsel_q;
   logic [BCW-1:0] bcnt_q;
   logic           fl_chk_q, fl_rd_q, fl_b7_q;
   logic [6:0]     sh_q;
   logic           done_q, err_q, bv_q;
   logic [7:0]     bd_q;
   logic [7:0]     txb;
   logic           last_rd;

   always_comb begin
      case (bsel_q)
         2'd0:    txb = {DEV_ADDR, 1'b0};
         2'd1:    txb = MEM_OFFSET;
         default: txb = {DEV_ADDR, 1'b1};
      endcase
   end

   assign last_rd  = (bcnt_q == BCW'(NBYTES - 1));
   assign op_valid = (seg_q != SQ_WAIT) && (seg_q != SQ_FIN);

   always_comb begin
      op_kind = OP_BIT;
      op_tx   = 1'b1;
      case (seg_q)
         SQ_STA, SQ_RSTA: op_kind = OP_START;
         SQ_STO:          op_kind = OP_STOP;
         SQ_TX:           op_tx   = bit_q[3] ? 1'b1 : txb[~bit_q[2:0]];
         SQ_RX:           op_tx   = bit_q[3] ? last_rd : 1'b1;
         default:         op_tx   = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q    <= SQ_WAIT;
         bit_q    <= '0;
         bsel_q   <= '0;
         bcnt_q   <= '0;
         fl_chk_q <= 1'b0;
         fl_rd_q  <= 1'b0;
         fl_b7_q  <= 1'b0;
         sh_q     <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         bv_q     <= 1'b0;
         bd_q     <= '0;
      end else begin
         bv_q <= 1'b0;
         if (seg_q == SQ_WAIT && en) seg_q <= SQ_STA;
         if (seg_q == SQ_FIN && !eng_busy) done_q <= 1'b1;
         if (op_ack) begin
            fl_chk_q <= (seg_q == SQ_TX) && bit_q[3];
            fl_rd_q  <= (seg_q == SQ_RX) && !bit_q[3];
            fl_b7_q  <= (bit_q == 4'd7);
            case (seg_q)
               SQ_STA: begin
                  seg_q  <= SQ_TX;
                  bsel_q <= 2'd0;
                  bit_q  <= '0;
               end
               SQ_TX: begin
                  if (!bit_q[3]) bit_q <= bit_q + 1'b1;
                  else begin
                     bit_q <= '0;
                     case (bsel_q)
                        2'd0: bsel_q <= 2'd1;
                        2'd1: seg_q  <= SQ_RSTA;
                        default: begin
                           seg_q  <= SQ_RX;
                           bcnt_q <= '0;
                        end
                     endcase
                  end
               end
               SQ_RSTA: begin
                  seg_q  <= SQ_TX;
                  bsel_q <= 2'd2;
               end
               SQ_RX: begin
                  if (!bit_q[3]) bit_q <= bit_q + 1'b1;
                  else begin
                     bit_q <= '0;
                     if (last_rd) seg_q <= SQ_STO;
                     else bcnt_q <= bcnt_q + 1'b1;
                  end
               end
               SQ_STO: seg_q <= SQ_FIN;
               default: ;
            endcase
         end
         if (rx_valid) begin
            if (fl_chk_q && rx_bit) begin
               err_q <= 1'b1;
               seg_q <= SQ_STO;
            end
            if (fl_rd_q) begin
               sh_q <= {sh_q[5:0], rx_bit};
               if (fl_b7_q) begin
                  bv_q <= 1'b1;
                  bd_q <= {sh_q, rx_bit};
               end
            end
         end
      end
   end

   assign byte_valid = bv_q;
   assign byte_data  = bd_q;
   assign done       = done_q;
   assign err        = err_q;
endmodule

// File: rtl/ecl_word_pack.sv
module ecl_word_pack #(
   parameter int WORDS      = 16,
   parameter int WORD_BYTES = 4,
   parameter int AW         = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   output logic                    wr_en,
   output logic [AW-1:0]           wr_addr,
   output logic [8*WORD_BYTES-1:0] wr_data
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = 8 * WORD_BYTES;
   localparam int LW = $clog2(WORD_BYTES);

   logic [LW-1:0] lane_q;
   logic [AW-1:0] widx_q;
   logic [DW-1:0] nxt_word;
   logic          last_lane;

   assign last_lane = (lane_q == LW'(WORD_BYTES - 1));

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      if (g == WORD_BYTES - 1) begin : g_top
         assign nxt_word[8*g +: 8] = byte_data;
      end else begin : g_held
         logic [7:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hold_q <= '0;
            else if (byte_valid && lane_q == LW'(g)) hold_q <= byte_data;
         end
         assign nxt_word[8*g +: 8] = hold_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q  <= '0;
         widx_q  <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (byte_valid) begin
            lane_q <= last_lane ? '0 : lane_q + 1'b1;
            if (last_lane) begin
               wr_en   <= 1'b1;
               wr_addr <= widx_q;
               wr_data <= nxt_word;
               widx_q  <= widx_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
   import ecl_pkg::*;
#(
   parameter int         HALF_CLKS  = 256,
   parameter int         WORDS      = 16,
   parameter int         WORD_BYTES = 4,
   parameter logic [6:0] DEV_ADDR   = 7'h50,
   parameter logic [7:0] MEM_OFFSET = 8'h00,
   localparam int        AW         = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int        DW         = 8 * WORD_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          sda_in,
   output logic          scl_out,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          done,
   output logic          err
);
   timeunit 1ns;
   timeprecision 1ps;

   if (HALF_CLKS < 4 || (HALF_CLKS % 2) != 0) begin : g_bad_half
      $error("HALF_CLKS must be even and at least 4");
   end
   if (WORD_BYTES < 2) begin : g_bad_bytes
      $error("WORD_BYTES must be at least 2");
   end
   if (WORDS < 1) begin : g_bad_words
      $error("WORDS must be at least 1");
   end

   logic       op_valid, op_ack, op_tx, eng_busy, rx_bit, rx_valid;
   op_e        op_kind;
   logic       byte_valid;
   logic [7:0] byte_data;

   ecl_bit_engine #(.HALF_CLKS(HALF_CLKS)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_kind  (op_kind),
      .op_tx    (op_tx),
      .sda_in   (sda_in),
      .op_ack   (op_ack),
      .busy     (eng_busy),
      .scl      (scl_out),
      .sda_oe   (sda_oe),
      .rx_bit   (rx_bit),
      .rx_valid (rx_valid)
   );

   ecl_sequencer #(
      .WORDS      (WORDS),
      .WORD_BYTES (WORD_BYTES),
      .DEV_ADDR   (DEV_ADDR),
      .MEM_OFFSET (MEM_OFFSET)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .op_ack     (op_ack),
      .eng_busy   (eng_busy),
      .rx_bit     (rx_bit),
      .rx_valid   (rx_valid),
      .op_valid   (op_valid),
      .op_kind    (op_kind),
      .op_tx      (op_tx),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .done       (done),
      .err        (err)
   );

   ecl_word_pack #(
      .WORDS      (WORDS),
      .WORD_BYTES (WORD_BYTES),
      .AW         (AW)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data)
   );
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
   parameter int HALF_CLKS = 256,
   parameter int WORDS     = 16,
   localparam int AW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_out,
   input logic          sda_oe,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          done,
   input logic          err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LCW = $clog2(HALF_CLKS + 1);

   logic [LCW-1:0] lo_cnt;
   logic [AW-1:0]  exp_a;
   logic [AW:0]    wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         exp_a  <= '0;
         wcnt   <= '0;
      end else begin
         lo_cnt <= scl_out ? '0 : lo_cnt + 1'b1;
         if (wr_en) begin
            exp_a <= exp_a + 1'b1;
            wcnt  <= wcnt + 1'b1;
         end
      end
   end

   p_scl_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_out) |-> lo_cnt == LCW'(HALF_CLKS));

   p_sda_mid_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_out && !$stable(sda_oe)) |-> lo_cnt == LCW'(HALF_CLKS / 2));

   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_addr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr == exp_a);

   p_write_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wcnt < (AW+1)'(WORDS));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_err_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wr_en);

   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   p_done_bus_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (scl_out && !sda_oe));
endmodule

bind eeprom_cfg_loader ecl_checker #(
   .HALF_CLKS (HALF_CLKS),
   .WORDS     (WORDS)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_out (scl_out),
   .sda_oe  (sda_oe),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .done    (done),
   .err     (err)
);

// File: tb/test_eeprom_cfg_loader.sv
module test_eeprom_cfg_loader;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int         H     = 8;
   localparam int         Q     = H / 2;
   localparam int         NW    = 4;
   localparam int         NB    = NW * 4;
   localparam int         AW    = 2;
   localparam logic [6:0] DEV   = 7'h50;
   localparam logic [7:0] OFFS  = 8'h20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          slave_low = 1'b0;
   logic          sda_in;
   logic          scl_out, sda_oe, wr_en, done, err;
   logic [AW-1:0] wr_addr;
   logic [31:0]   wr_data;

   assign sda_in = ~(sda_oe | slave_low);

   eeprom_cfg_loader #(
      .HALF_CLKS  (H),
      .WORDS      (NW),
      .WORD_BYTES (4),
      .DEV_ADDR   (DEV),
      .MEM_OFFSET (OFFS)
   ) i_eeprom_cfg_loader (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .sda_in  (sda_in),
      .scl_out (scl_out),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .done    (done),
      .err     (err)
   );

   always #2 clk = ~clk;

   int          checks = 0;
   int          errors = 0;
   bit          chk_on = 1'b0;
   bit          finished = 1'b0;
   logic        exp_scl = 1'b1, exp_oe = 1'b0, exp_wr = 1'b0;
   logic        exp_done = 1'b0, exp_err = 1'b0;
   logic [31:0] exp_data = '0;
   logic [AW-1:0] exp_addr = '0;
   string       tag_scl = "R1", tag_oe = "R1";
   logic [7:0]  mem [NB];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk(tag_scl, "scl_out", 32'(scl_out), 32'(exp_scl));
         chk(tag_oe, "sda_oe", 32'(sda_oe), 32'(exp_oe));
         chk("R8", "wr_en", 32'(wr_en), 32'(exp_wr));
         chk("R10", "done", 32'(done), 32'(exp_done));
         chk("R9", "err", 32'(err), 32'(exp_err));
         if (exp_wr) begin
            chk("R8", "wr_addr", 32'(wr_addr), 32'(exp_addr));
            chk("R7", "wr_data", wr_data, exp_data);
         end
      end
   end

   task automatic wait_edges(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   function automatic logic [31:0] word_of(int w);
      return {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
   endfunction

   // one bit slot, entered just after its first edge
   task automatic ref_bit(logic tx, logic sbit, bit emit, int widx, bit set_err);
      tag_scl = "R2";
      exp_scl = 1'b0;
      slave_low = ~sbit;
      wait_edges(Q);
      exp_oe = ~tx;
      wait_edges(H - Q);
      exp_scl = 1'b1;
      wait_edges(Q);
      wait_edges(1);
      if (set_err) exp_err = 1'b1;
      wait_edges(1);
      if (emit) begin
         exp_wr = 1'b1;
         exp_addr = AW'(widx);
         exp_data = word_of(widx);
      end
      wait_edges(1);
      exp_wr = 1'b0;
      wait_edges(H - Q - 3);
   endtask

   task automatic ref_start();
      tag_scl = "R3";
      tag_oe = "R3";
      exp_scl = 1'b0;
      slave_low = 1'b0;
      wait_edges(Q);
      exp_oe = 1'b0;
      wait_edges(H - Q);
      exp_scl = 1'b1;
      wait_edges(H);
      exp_oe = 1'b1;
      wait_edges(H);
   endtask

   task automatic ref_stop();
      tag_scl = "R3";
      tag_oe = "R3";
      exp_scl = 1'b0;
      slave_low = 1'b0;
      wait_edges(Q);
      exp_oe = 1'b1;
      wait_edges(H - Q);
      exp_scl = 1'b1;
      wait_edges(H);
      exp_oe = 1'b0;
      wait_edges(H);
      wait_edges(1);
      exp_done = 1'b1;
   endtask

   // R5 byte the loader sends, R9 when the slave withholds its ACK
   task automatic ref_wbyte(logic [7:0] b, bit nack);
      tag_oe = "R5";
      for (int i = 7; i >= 0; i--) ref_bit(b[i], 1'b1, 1'b0, 0, 1'b0);
      ref_bit(1'b1, nack, 1'b0, 0, nack);
   endtask

   task automatic ref_rbyte(int k);
      tag_oe = "R4";
      for (int i = 7; i >= 0; i--)
         ref_bit(1'b1, mem[k][i], (i == 0) && (k % 4 == 3), k / 4, 1'b0);
      tag_oe = "R6";
      ref_bit(k == NB - 1, 1'b1, 1'b0, 0, 1'b0);
   endtask

   task automatic run(int nack_at);
      @(negedge clk);
      en = 1'b1;
      wait_edges(2);
      ref_start();
      ref_wbyte({DEV, 1'b0}, nack_at == 1);
      if (nack_at == 1) begin ref_stop(); wait_edges(30); return; end
      ref_wbyte(OFFS, nack_at == 2);
      if (nack_at == 2) begin ref_stop(); wait_edges(30); return; end
      ref_start();
      ref_wbyte({DEV, 1'b1}, nack_at == 3);
      if (nack_at == 3) begin ref_stop(); wait_edges(30); return; end
      for (int k = 0; k < NB; k++) ref_rbyte(k);
      ref_stop();
      wait_edges(30);
   endtask

   task automatic do_reset();
      @(negedge clk);
      en = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      tag_scl = "R1";
      tag_oe = "R1";
      exp_scl = 1'b1;
      exp_oe = 1'b0;
      exp_wr = 1'b0;
      exp_done = 1'b0;
      exp_err = 1'b0;
      slave_low = 1'b0;
      wait_edges(3);
      @(negedge clk);
      rst_n = 1'b1;
      wait_edges(10);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) mem[i] = 8'(i * 29 + 3);
      wait_edges(3);
      chk_on = 1'b1;
      wait_edges(4);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: idle while en is low
      wait_edges(40);
      run(0);
      do_reset();
      run(1);
      do_reset();
      run(2);
      do_reset();
      run(3);
      do_reset();
      for (int i = 0; i < NB; i++) mem[i] = i[0] ? 8'h80 : 8'h01;
      run(0);
      chk_on = 1'b0;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule